// File: doc/BRIEF.md
# Display Mode Index/Data Register File

This block is the control-register front end of a linear-framebuffer graphics mode. A host reaches it through two ports: an index port that selects one of sixteen 16-bit mode registers, and a data port that reads or writes the selected register. The data port can be written as a whole word or one byte lane at a time. The registers cover the visible resolution, the colour depth, a mode control word, a bank selector, the virtual line width, the pan offsets, a read-only memory size, and a bit-banged display-data-channel (DDC) register.

Beyond plain storage, the block does several things. It can substitute hardware capability limits for the stored resolution, depth and bank values on readback. It accepts only a fixed set of identification values. It turns bank selector writes into byte addresses for separate read and write windows, with a selectable 32 KiB or 64 KiB granularity. It drives the DDC clock and data lines and reflects their sensed levels. When the mode is switched on it clears the pan state and issues a one-cycle request to clear the framebuffer. Every register write takes effect at the clock edge that samples it, and readback is combinational from the registered state.

Top module: `gfx_mode_regs`

## Requirements
- R1: After reset the index is 0, every stored register is 0, both bank bases are 0, granularity is 64 KiB, the DDC drives are high (released), `dac_8bit` is 0 and `clear_req` is 0.
- R2: `acc_port` encodes 0 = index word, 1 = data low lane, 2 = data high lane, 3 = data word. Indices 1 (width), 2 (height), 3 (depth), 6 (virtual width), 8 (X pan) and 9 (Y pan) store a full written word and read it back. Index 7 and every index of 0xC or above read 0 and ignore writes. Index 0xA reads `MEM_UNITS` (memory size in 64 KiB units) and ignores writes.
- R3: While bit 1 of the mode control word (index 4) is set, reads of index 1 return `MAX_X`, index 2 `MAX_Y`, index 3 `MAX_BPP` and index 5 0x1000. While it is clear, those reads return the stored values.
- R4: A write to index 0 stores the value when it lies in 0xB0C0..0xB0C4, stores `REV_VALUE` when the value is 0xB0C5, and is otherwise ignored.
- R5: A write to index 5 stores the word. With bit 15 set it loads the read bank base, and with bit 14 set it loads the write bank base. The base is bits [8:0] times the granularity in bytes.
- R6: Bit 4 of a mode control write selects 32 KiB granularity when set and 64 KiB when clear. A change of granularity zeroes both bank bases.
- R7: A mode control write with bit 0 set while the stored bit 0 is clear zeroes the X pan, Y pan and virtual width. It pulses `clear_req` high for the one following cycle unless bit 7 is set. Bit 7 is never stored.
- R8: Any other mode control write zeroes both bank bases.
- R9: `dac_8bit` follows bit 5 of the stored mode control word.
- R10: A write to index 0xB with bit 7 set stores the word and drives `ddc_scl_o` from bit 0 and `ddc_sda_o` from bit 1. With bit 7 clear, it only clears the stored bit 7 and leaves the drives unchanged.
- R11: Reading index 0xB with stored bit 7 set returns stored bits 7, 1 and 0. Bit 2 is added when stored bit 0 is set and `ddc_scl_i` is high. Bit 3 is added when stored bit 1 is set and `ddc_sda_i` is high. With stored bit 7 clear, the read returns 0x000F.
- R12: A byte-lane data write takes the other byte from the current readback value of the selected register. It then acts exactly as a word write of the merged value, including the ID filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_port | input | 2 | 0 index, 1 data low byte, 2 data high byte, 3 data word |
| acc_wdata | input | 16 | Write value (byte lanes use bits 7:0) |
| rd_index | output | 16 | Current index register |
| rd_data | output | 16 | Readback of the selected register |
| rd_bank_base | output | 25 | Byte base of the read bank window |
| wr_bank_base | output | 25 | Byte base of the write bank window |
| dac_8bit | output | 1 | Palette DAC width select (1 = 8-bit) |
| clear_req | output | 1 | One-cycle framebuffer clear request |
| ddc_scl_o | output | 1 | DDC clock drive |
| ddc_sda_o | output | 1 | DDC data drive |
| ddc_scl_i | input | 1 | DDC clock sense |
| ddc_sda_i | input | 1 | DDC data sense |

## Verification
The bench switches the mode on while a bank is already selected and the granularity is unchanged. A design that zeroed the bases on every control write would lose the window there, and one that never zeroed them would keep stale bases on the second, non-rising enable write. It sends an out-of-set ID, the magic revision value and a byte-lane ID write, so a missing filter or a lane merge taken from the wrong byte shows up as a wrong readback. The DDC cases pair each drive bit with opposite sense levels and include a write with bit 7 clear, which catches sense bits that ignore the drive gate and drives that move when they should be held.

// File: rtl/gmr_pkg.sv
package gmr_pkg;

    localparam int BANK_BITS = 9;
    localparam int BASE_W    = BANK_BITS + 16;

    localparam logic [1:0] PORT_INDEX = 2'd0;
    localparam logic [1:0] PORT_LO    = 2'd1;
    localparam logic [1:0] PORT_HI    = 2'd2;
    localparam logic [1:0] PORT_WORD  = 2'd3;

    localparam logic [3:0] IX_ID    = 4'h0;
    localparam logic [3:0] IX_XRES  = 4'h1;
    localparam logic [3:0] IX_YRES  = 4'h2;
    localparam logic [3:0] IX_BPP   = 4'h3;
    localparam logic [3:0] IX_CTRL  = 4'h4;
    localparam logic [3:0] IX_BANK  = 4'h5;
    localparam logic [3:0] IX_VWID  = 4'h6;
    localparam logic [3:0] IX_VHGT  = 4'h7;
    localparam logic [3:0] IX_XOFF  = 4'h8;
    localparam logic [3:0] IX_YOFF  = 4'h9;
    localparam logic [3:0] IX_MEM   = 4'hA;
    localparam logic [3:0] IX_DDC   = 4'hB;

    localparam int CTRL_ON    = 0;
    localparam int CTRL_CAPS  = 1;
    localparam int CTRL_GRAN  = 4;
    localparam int CTRL_DAC8  = 5;
    localparam int CTRL_NOCLR = 7;

    typedef struct packed {
        logic [15:0]       index;
        logic [15:0]       id;
        logic [15:0]       xres;
        logic [15:0]       yres;
        logic [15:0]       bpp;
        logic [15:0]       ctrl;
        logic [15:0]       bank;
        logic [15:0]       vwid;
        logic [15:0]       xoff;
        logic [15:0]       yoff;
        logic [15:0]       ddc;
        logic              gran32;
        logic [BASE_W-1:0] rbase;
        logic [BASE_W-1:0] wbase;
        logic              scl;
        logic              sda;
        logic              clr;
    } gmr_state_t;

endpackage

// File: rtl/gmr_bankcalc.sv
module gmr_bankcalc
    import gmr_pkg::*;
(
    input  logic [BANK_BITS-1:0] bank_num,
    input  logic                 gran32,
    output logic [BASE_W-1:0]    base
);
    localparam int SHIFT_SMALL = 15;
    localparam int SHIFT_LARGE = 16;

    logic [BASE_W-1:0] wide;

    always_comb begin
        wide = {{(BASE_W-BANK_BITS){1'b0}}, bank_num};
        base = gran32 ? (wide << SHIFT_SMALL) : (wide << SHIFT_LARGE);
    end
endmodule

// File: rtl/gmr_readmux.sv
module gmr_readmux
    import gmr_pkg::*;
#(
    parameter logic [15:0] MAX_X     = 16'd1920,
    parameter logic [15:0] MAX_Y     = 16'd1600,
    parameter logic [15:0] MAX_BPP   = 16'd32,
    parameter logic [15:0] MEM_UNITS = 16'd256
) (
    input  gmr_state_t  st,
    input  logic        scl_sense,
    input  logic        sda_sense,
    output logic [15:0] data
);
    localparam logic [15:0] CAPS_BANK = 16'h0010 << 8;
    localparam logic [15:0] DDC_IDLE  = 16'h000F;

    logic caps;
    logic hi_idx;

    always_comb begin
        caps   = st.ctrl[CTRL_CAPS];
        hi_idx = |st.index[15:4];
        data   = '0;
        if (!hi_idx) begin
            unique case (st.index[3:0])
                IX_ID:   data = st.id;
                IX_XRES: data = caps ? MAX_X   : st.xres;
                IX_YRES: data = caps ? MAX_Y   : st.yres;
                IX_BPP:  data = caps ? MAX_BPP : st.bpp;
                IX_CTRL: data = st.ctrl;
                IX_BANK: data = caps ? CAPS_BANK : st.bank;
                IX_VWID: data = st.vwid;
                IX_XOFF: data = st.xoff;
                IX_YOFF: data = st.yoff;
                IX_MEM:  data = MEM_UNITS;
                IX_DDC: begin
                    if (st.ddc[7]) begin
                        data    = st.ddc & 16'h0083;
                        data[2] = st.ddc[0] & scl_sense;
                        data[3] = st.ddc[1] & sda_sense;
                    end else begin
                        data = DDC_IDLE;
                    end
                end
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gfx_mode_regs.sv
module gfx_mode_regs
    import gmr_pkg::*;
#(
    parameter logic [15:0] MAX_X     = 16'd1920,
    parameter logic [15:0] MAX_Y     = 16'd1600,
    parameter logic [15:0] MAX_BPP   = 16'd32,
    parameter logic [15:0] MEM_UNITS = 16'd256,
    parameter logic [15:0] REV_VALUE = 16'hB0C5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_port,
    input  logic [15:0]       acc_wdata,
    output logic [15:0]       rd_index,
    output logic [15:0]       rd_data,
    output logic [BASE_W-1:0] rd_bank_base,
    output logic [BASE_W-1:0] wr_bank_base,
    output logic              dac_8bit,
    output logic              clear_req,
    output logic              ddc_scl_o,
    output logic              ddc_sda_o,
    input  logic              ddc_scl_i,
    input  logic              ddc_sda_i
);
    localparam logic [15:0] ID_LOW   = 16'hB0C0;
    localparam logic [15:0] ID_HIGH  = 16'hB0C4;
    localparam logic [15:0] ID_MAGIC = 16'hB0C5;

    gmr_state_t st_q, st_d;

    logic [15:0]       cur_data;
    logic [15:0]       wword;
    logic [BASE_W-1:0] new_base;
    logic              data_wr;

    gmr_readmux #(
        .MAX_X    (MAX_X),
        .MAX_Y    (MAX_Y),
        .MAX_BPP  (MAX_BPP),
        .MEM_UNITS(MEM_UNITS)
    ) u_rmux (
        .st       (st_q),
        .scl_sense(ddc_scl_i),
        .sda_sense(ddc_sda_i),
        .data     (cur_data)
    );

    gmr_bankcalc u_bcalc (
        .bank_num(wword[BANK_BITS-1:0]),
        .gran32  (st_q.gran32),
        .base    (new_base)
    );

    always_comb begin
        unique case (acc_port)
            PORT_LO: wword = {cur_data[15:8], acc_wdata[7:0]};
            PORT_HI: wword = {acc_wdata[7:0], cur_data[7:0]};
            default: wword = acc_wdata;
        endcase
        data_wr = acc_valid && acc_write && (acc_port != PORT_INDEX)
                  && !(|st_q.index[15:4]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (acc_valid && acc_write && acc_port == PORT_INDEX)
            st_d.index = acc_wdata;
        if (data_wr) begin
            unique case (st_q.index[3:0])
                IX_ID: begin
                    if (wword >= ID_LOW && wword <= ID_HIGH)
                        st_d.id = wword;
                    else if (wword == ID_MAGIC)
                        st_d.id = REV_VALUE;
                end
                IX_XRES: st_d.xres = wword;
                IX_YRES: st_d.yres = wword;
                IX_BPP:  st_d.bpp  = wword;
                IX_VWID: st_d.vwid = wword;
                IX_XOFF: st_d.xoff = wword;
                IX_YOFF: st_d.yoff = wword;
                IX_BANK: begin
                    st_d.bank = wword;
                    if (wword[15]) st_d.rbase = new_base;
                    if (wword[14]) st_d.wbase = new_base;
                end
                IX_CTRL: begin
                    st_d.ctrl              = wword;
                    st_d.ctrl[CTRL_NOCLR]  = 1'b0;
                    if (wword[CTRL_ON] && !st_q.ctrl[CTRL_ON]) begin
                        st_d.xoff = '0;
                        st_d.yoff = '0;
                        st_d.vwid = '0;
                        st_d.clr  = !wword[CTRL_NOCLR];
                    end else begin
                        st_d.rbase = '0;
                        st_d.wbase = '0;
                    end
                    if (wword[CTRL_GRAN] != st_q.gran32) begin
                        st_d.gran32 = wword[CTRL_GRAN];
                        st_d.rbase  = '0;
                        st_d.wbase  = '0;
                    end
                end
                IX_DDC: begin
                    if (wword[7]) begin
                        st_d.ddc = wword;
                        st_d.scl = wword[0];
                        st_d.sda = wword[1];
                    end else begin
                        st_d.ddc[7] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.scl <= 1'b1;
            st_q.sda <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_index     = st_q.index;
    assign rd_data      = cur_data;
    assign rd_bank_base = st_q.rbase;
    assign wr_bank_base = st_q.wbase;
    assign dac_8bit     = st_q.ctrl[CTRL_DAC8];
    assign clear_req    = st_q.clr;
    assign ddc_scl_o    = st_q.scl;
    assign ddc_sda_o    = st_q.sda;
endmodule

// File: rtl/gmr_check.sv
module gmr_check #(
    parameter int BASE_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_port,
    input logic [15:0]       acc_wdata,
    input logic [15:0]       rd_index,
    input logic [15:0]       rd_data,
    input logic [BASE_W-1:0] rd_bank_base,
    input logic [BASE_W-1:0] wr_bank_base,
    input logic              dac_8bit,
    input logic              clear_req
);
    logic ctrl_word_wr;
    assign ctrl_word_wr = acc_valid && acc_write && acc_port == 2'd3
                          && rd_index == 16'h0004;

    // R5
    bank_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bank_base[14:0] == 15'd0) && (wr_bank_base[14:0] == 15'd0));

    // R9
    dac_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word_wr |=> (dac_8bit == $past(acc_wdata[5])));

    // R7
    noclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word_wr && acc_wdata[7]) |=> !clear_req);

    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !clear_req);

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_index >= 16'h000C) |-> (rd_data == 16'h0000));

    // R4
    id_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_port == 2'd3 && rd_index == 16'h0000
         && acc_wdata == 16'h1234) |=> (rd_data == $past(rd_data)));
endmodule

bind gfx_mode_regs gmr_check #(.BASE_W(gmr_pkg::BASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_port    (acc_port),
    .acc_wdata   (acc_wdata),
    .rd_index    (rd_index),
    .rd_data     (rd_data),
    .rd_bank_base(rd_bank_base),
    .wr_bank_base(wr_bank_base),
    .dac_8bit    (dac_8bit),
    .clear_req   (clear_req)
);

// File: tb/sim_gfx_mode_regs.sv
module sim_gfx_mode_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_port = 2'd0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] rd_index;
    logic [15:0] rd_data;
    logic [24:0] rd_bank_base;
    logic [24:0] wr_bank_base;
    logic        dac_8bit;
    logic        clear_req;
    logic        ddc_scl_o;
    logic        ddc_sda_o;
    logic        ddc_scl_i = 1'b0;
    logic        ddc_sda_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gfx_mode_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_port(acc_port), .acc_wdata(acc_wdata),
        .rd_index(rd_index), .rd_data(rd_data),
        .rd_bank_base(rd_bank_base), .wr_bank_base(wr_bank_base),
        .dac_8bit(dac_8bit), .clear_req(clear_req),
        .ddc_scl_o(ddc_scl_o), .ddc_sda_o(ddc_sda_o),
        .ddc_scl_i(ddc_scl_i), .ddc_sda_i(ddc_sda_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] port, input logic [15:0] val);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = 1'b1;
        acc_port  = port;
        acc_wdata = val;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic reg_wr(input logic [15:0] idx, input logic [15:0] val);
        put(2'd0, idx);
        put(2'd3, val);
    endtask

    task automatic reg_rd(input logic [15:0] idx, output logic [15:0] val);
        put(2'd0, idx);
        val = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 index", rd_index, 0);
        check("R1 id", rd_data, 0);
        check("R1 rbase", rd_bank_base, 0);
        check("R1 wbase", wr_bank_base, 0);
        check("R1 drives", {ddc_scl_o, ddc_sda_o}, 2'b11);
        check("R1 dac", dac_8bit, 0);
        check("R1 clr", clear_req, 0);
        reg_rd(16'h0004, v); check("R1 ctrl", v, 0);
        reg_rd(16'h0001, v); check("R1 xres", v, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        reg_wr(16'h0001, 16'h0280); reg_rd(16'h0001, v); check("R2 xres", v, 16'h0280);
        reg_wr(16'h0009, 16'h1234); reg_rd(16'h0009, v); check("R2 yoff", v, 16'h1234);
        reg_wr(16'h0007, 16'h0055); reg_rd(16'h0007, v); check("R2 vhgt", v, 0);
        reg_wr(16'h000D, 16'h00AA); reg_rd(16'h000D, v); check("R2 idx D", v, 0);
        reg_wr(16'h000A, 16'h0005); reg_rd(16'h000A, v); check("R2 mem", v, 16'd256);
        check("R2 index port", rd_index, 16'h000A);
    endtask

    task automatic t_caps();
        logic [15:0] v;
        reg_wr(16'h0005, 16'h0003);
        reg_wr(16'h0004, 16'h0002);
        reg_rd(16'h0001, v); check("R3 maxx", v, 16'd1920);
        reg_rd(16'h0002, v); check("R3 maxy", v, 16'd1600);
        reg_rd(16'h0003, v); check("R3 maxbpp", v, 16'd32);
        reg_rd(16'h0005, v); check("R3 bankcaps", v, 16'h1000);
        reg_wr(16'h0004, 16'h0000);
        reg_rd(16'h0001, v); check("R3 live xres", v, 16'h0280);
        reg_rd(16'h0005, v); check("R3 live bank", v, 16'h0003);
    endtask

    task automatic t_id();
        logic [15:0] v;
        reg_wr(16'h0000, 16'hB0C2); reg_rd(16'h0000, v); check("R4 accept", v, 16'hB0C2);
        reg_wr(16'h0000, 16'h1234); reg_rd(16'h0000, v); check("R4 reject", v, 16'hB0C2);
        reg_wr(16'h0000, 16'hB0C6); reg_rd(16'h0000, v); check("R4 reject hi", v, 16'hB0C2);
        reg_wr(16'h0000, 16'hB0C5); reg_rd(16'h0000, v); check("R4 magic", v, 16'hB0C5);
        reg_wr(16'h0000, 16'hB0C4); reg_rd(16'h0000, v); check("R4 top", v, 16'hB0C4);
    endtask

    task automatic t_bank();
        logic [15:0] v;
        reg_wr(16'h0005, 16'h8003);
        check("R5 rd only r", rd_bank_base, 25'h0030000);
        check("R5 rd only w", wr_bank_base, 0);
        reg_wr(16'h0005, 16'h4005);
        check("R5 wr only w", wr_bank_base, 25'h0050000);
        check("R5 wr only r", rd_bank_base, 25'h0030000);
        reg_wr(16'h0005, 16'hC1FF);
        check("R5 both r", rd_bank_base, 25'h1FF0000);
        check("R5 both w", wr_bank_base, 25'h1FF0000);
        reg_rd(16'h0005, v); check("R5 stored", v, 16'hC1FF);
    endtask

    task automatic t_gran_enable();
        logic [15:0] v;
        reg_wr(16'h0004, 16'h0010);
        check("R6 change zero", rd_bank_base, 0);
        reg_wr(16'h0005, 16'hC002);
        check("R6 32k base", rd_bank_base, 25'h0010000);
        reg_wr(16'h0008, 16'h0005);
        reg_wr(16'h0009, 16'h0006);
        reg_wr(16'h0006, 16'd640);
        reg_wr(16'h0004, 16'h0011);
        check("R7 clr pulse", clear_req, 1);
        check("R7 bases kept", rd_bank_base, 25'h0010000);
        @(negedge clk);
        check("R7 pulse ends", clear_req, 0);
        reg_rd(16'h0008, v); check("R7 xoff", v, 0);
        reg_rd(16'h0009, v); check("R7 yoff", v, 0);
        reg_rd(16'h0006, v); check("R7 vwid", v, 0);
        reg_wr(16'h0004, 16'h0011);
        check("R8 again no clr", clear_req, 0);
        check("R8 rbase zero", rd_bank_base, 0);
        check("R8 wbase zero", wr_bank_base, 0);
    endtask

    task automatic t_noclear();
        logic [15:0] v;
        reg_wr(16'h0004, 16'h0000);
        reg_wr(16'h0008, 16'h0007);
        reg_wr(16'h0004, 16'h0081);
        check("R7 noclr", clear_req, 0);
        reg_rd(16'h0004, v); check("R7 bit7 dropped", v, 16'h0001);
        reg_rd(16'h0008, v); check("R7 xoff noclr", v, 0);
    endtask

    task automatic t_dac();
        reg_wr(16'h0004, 16'h0020); check("R9 dac8", dac_8bit, 1);
        reg_wr(16'h0004, 16'h0000); check("R9 dac6", dac_8bit, 0);
    endtask

    task automatic t_ddc();
        logic [15:0] v;
        reg_rd(16'h000B, v); check("R11 idle", v, 16'h000F);
        ddc_scl_i = 1'b1; ddc_sda_i = 1'b1;
        reg_wr(16'h000B, 16'h0081);
        check("R10 drives 81", {ddc_scl_o, ddc_sda_o}, 2'b10);
        check("R11 scl hi", rd_data, 16'h0085);
        ddc_scl_i = 1'b0;
        @(negedge clk);
        check("R11 scl lo", rd_data, 16'h0081);
        ddc_scl_i = 1'b1;
        reg_wr(16'h000B, 16'h0083);
        check("R10 drives 83", {ddc_scl_o, ddc_sda_o}, 2'b11);
        check("R11 both", rd_data, 16'h008F);
        reg_wr(16'h000B, 16'h0000);
        check("R10 held", {ddc_scl_o, ddc_sda_o}, 2'b11);
        check("R11 after clear", rd_data, 16'h000F);
        reg_wr(16'h000B, 16'h0080);
        check("R10 drives 80", {ddc_scl_o, ddc_sda_o}, 2'b00);
        check("R11 no drive", rd_data, 16'h0080);
    endtask

    task automatic t_byte();
        logic [15:0] v;
        put(2'd0, 16'h0001);
        put(2'd1, 16'h0040); check("R12 low lane", rd_data, 16'h0240);
        put(2'd2, 16'h0005); check("R12 high lane", rd_data, 16'h0540);
        put(2'd0, 16'h0000);
        put(2'd1, 16'h00C1); check("R12 id lane", rd_data, 16'hB0C1);
        put(2'd2, 16'h0012); check("R12 id lane reject", rd_data, 16'hB0C1);
        reg_rd(16'h0001, v); check("R12 xres keep", v, 16'h0540);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_caps();
        t_id();
        t_bank();
        t_gran_enable();
        t_noclear();
        t_dac();
        t_ddc();
        t_byte();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule